// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

This block sits between a clocked on-chip bus and an external asynchronous static RAM that is 16 bits wide and 524288 words deep. The host issues one request at a time: an address, a read/write flag, write data and a byte mask. The controller turns each request into a sequence of select, byte-enable, write-strobe and output-enable levels on the RAM pins. Every level is held long enough to meet the RAM's minimum times. Those times are given as nanosecond parameters and turned into clock counts from the clock period, so the same RTL fits any clock rate.

The RAM has two chip selects of opposite polarity and one active-low enable per byte lane. The shared data bus is modelled as an output word, an input word and a drive-enable. The controller drives the bus only while a write is in progress. Every access ends with a cycle in which all strobes are inactive, so a read is always separated from the write that follows it.

Each nanosecond minimum becomes ceil(t / clock period) cycles, with a floor of one cycle. The write-strobe width is the larger of the pulse minimum and the address-to-end-of-write minimum. Write recovery stretches the write so that the whole write meets the cycle minimum, and it is never shorter than one cycle.

Top module: `sram_bus_ctl`

## Requirements
- R1: While reset is high and in the cycle after it falls, the controller is in standby: chip select 1 high, chip select 2 low, every byte enable high, write strobe high, output enable high, data drive off and ready high.
- R2: The select pair is active (chip select 1 low, chip select 2 high) only during a read or a write, and the two selects are always opposite. Outside an access every byte enable is high.
- R3: For a write, the write strobe falls in the same cycle as the selects become active. It stays low for max(ceil(T_WP/P), ceil(T_AW/P)) cycles, which is 9 at the default 8 ns period. The selects and the data stay on for a total of max(ceil(T_WC/P), strobe cycles + 1) cycles, which is 11 at the defaults.
- R4: Byte mask bit 0 selects the lower lane (data bits 7:0, byte enable bit 0) and mask bit 1 selects the upper lane (bits 15:8, byte enable bit 1). Only masked lanes have their enable low, so a masked write leaves the other lane of the RAM word unchanged.
- R5: For a read, output enable is low and the write strobe high for ceil(T_RC/P) cycles, which is 11 at the defaults. The data pins are sampled on the last of those cycles. The result appears on the read-data output with a one-cycle valid pulse in the first cycle of ready, and unmasked lanes read as zero.
- R6: The data drive-enable is high only during a write. It is never high while output enable is low, and output enable and write strobe are never low together.
- R7: Ready is high only when no request is in flight. A request is accepted on a clock edge where valid and ready are both high. Ready is low from the next cycle until the access has finished.
- R8: The RAM address equals the accepted request address and stays stable in every cycle of the access.
- R9: A request with an empty byte mask runs its full timing but keeps both byte enables high, so the RAM stays non-selected. A write then changes nothing and a read returns zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Controller can accept a request |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 19 | Word address |
| req_wdata | input | 16 | Write data |
| req_mask | input | 2 | Byte lanes to access, bit 0 = lower byte |
| rsp_valid | output | 1 | One-cycle pulse when read data is ready |
| rsp_rdata | output | 16 | Read data, unmasked lanes zero |
| ram_addr | output | 19 | RAM address pins |
| ram_cs1_n | output | 1 | Chip select 1, active low |
| ram_cs2 | output | 1 | Chip select 2, active high |
| ram_be_n | output | 2 | Byte enables, active low, bit 0 = lower byte |
| ram_we_n | output | 1 | Write strobe, active low |
| ram_oe_n | output | 1 | Output enable, active low |
| ram_dq_o | output | 16 | Data driven toward the RAM |
| ram_dq_oe | output | 1 | Drive enable for the data bus |
| ram_dq_i | input | 16 | Data read from the RAM pins |

## Verification
The hardest case to reach from the ports is a read followed directly by a write on the same address with different masks. Here the bus turnaround, the lane isolation and the read-after-write path all matter at once. The stimulus issues each request in the first cycle ready allows, so every access runs back to back. A random mix over a small address window makes the same word keep coming back with different masks, including the empty mask. A bench RAM model refuses to take data while its own outputs would be driving, and it returns garbage on lanes that are not enabled. A masking or contention error therefore shows up as a data mismatch.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

    localparam int unsigned DEF_ADDR_W = 19;
    localparam int unsigned DEF_DATA_W = 16;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2,
        ST_WREC  = 2'd3
    } ctl_state_e;

    // Pin levels for one state, all registered together
    typedef struct packed {
        logic cs1_n;
        logic cs2;
        logic we_n;
        logic oe_n;
        logic dq_oe;
    } strobe_t;

    // Nanoseconds to cycles, rounded up, never below one
    function automatic int unsigned ns_to_cyc(int unsigned t_ns, int unsigned per_ns);
        int unsigned c;
        c = (t_ns + per_ns - 1) / per_ns;
        return (c == 0) ? 1 : c;
    endfunction

    function automatic int unsigned max_u(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

    function automatic strobe_t strobes_for(ctl_state_e st);
        strobe_t s;
        s = '{cs1_n: 1'b1, cs2: 1'b0, we_n: 1'b1, oe_n: 1'b1, dq_oe: 1'b0};
        case (st)
            ST_READ:  s = '{cs1_n: 1'b0, cs2: 1'b1, we_n: 1'b1, oe_n: 1'b0, dq_oe: 1'b0};
            ST_WRITE: s = '{cs1_n: 1'b0, cs2: 1'b1, we_n: 1'b0, oe_n: 1'b1, dq_oe: 1'b1};
            ST_WREC:  s = '{cs1_n: 1'b0, cs2: 1'b1, we_n: 1'b1, oe_n: 1'b1, dq_oe: 1'b1};
            default:  ;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/sram_ctl_timer.sv
module sram_ctl_timer #(
    parameter int unsigned CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/sram_ctl_lanes.sv
module sram_ctl_lanes #(
    parameter int unsigned DATA_W = 16,
    localparam int unsigned LANES = DATA_W / 8
) (
    input  logic              active,
    input  logic [LANES-1:0]  mask,
    input  logic [DATA_W-1:0] dq_in,
    output logic [LANES-1:0]  be_n,
    output logic [DATA_W-1:0] rd_masked
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign be_n[g]            = ~(active & mask[g]);
        assign rd_masked[g*8 +: 8] = mask[g] ? dq_in[g*8 +: 8] : 8'h00;
    end

endmodule

// File: rtl/sram_bus_ctl.sv
module sram_bus_ctl
    import sram_ctl_pkg::*;
#(
    parameter int unsigned ADDR_W        = DEF_ADDR_W,
    parameter int unsigned DATA_W        = DEF_DATA_W,
    parameter int unsigned CLK_PERIOD_NS = 8,
    parameter int unsigned T_RC_NS       = 85,
    parameter int unsigned T_WC_NS       = 85,
    parameter int unsigned T_WP_NS       = 60,
    parameter int unsigned T_AW_NS       = 70,
    localparam int unsigned LANES        = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_we,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [LANES-1:0]  req_mask,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] ram_addr,
    output logic              ram_cs1_n,
    output logic              ram_cs2,
    output logic [LANES-1:0]  ram_be_n,
    output logic              ram_we_n,
    output logic              ram_oe_n,
    output logic [DATA_W-1:0] ram_dq_o,
    output logic              ram_dq_oe,
    input  logic [DATA_W-1:0] ram_dq_i
);
    localparam int unsigned RC_CYC  = ns_to_cyc(T_RC_NS, CLK_PERIOD_NS);
    localparam int unsigned WP_CYC  = max_u(ns_to_cyc(T_WP_NS, CLK_PERIOD_NS),
                                            ns_to_cyc(T_AW_NS, CLK_PERIOD_NS));
    localparam int unsigned WC_CYC  = ns_to_cyc(T_WC_NS, CLK_PERIOD_NS);
    localparam int unsigned REC_CYC = (WC_CYC > WP_CYC) ? (WC_CYC - WP_CYC) : 1;
    localparam int unsigned MAX_CYC = max_u(RC_CYC, max_u(WP_CYC, REC_CYC));
    localparam int unsigned CNT_W   = $clog2(MAX_CYC + 1);

    ctl_state_e        state_q, state_d;
    strobe_t           strb_q;
    logic              tmr_load, tmr_expired, capture;
    logic [CNT_W-1:0]  tmr_val;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q, rd_masked;
    logic [LANES-1:0]  mask_q;
    logic              accept;

    assign req_ready = (state_q == ST_IDLE);
    assign accept    = req_valid && req_ready;

    sram_ctl_timer #(.CNT_W(CNT_W)) timer_i (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        capture  = 1'b0;
        case (state_q)
            ST_IDLE: if (accept) begin
                tmr_load = 1'b1;
                state_d  = req_we ? ST_WRITE : ST_READ;
                tmr_val  = req_we ? CNT_W'(WP_CYC - 1) : CNT_W'(RC_CYC - 1);
            end
            ST_READ: if (tmr_expired) begin
                capture = 1'b1;
                state_d = ST_IDLE;
            end
            ST_WRITE: if (tmr_expired) begin
                tmr_load = 1'b1;
                tmr_val  = CNT_W'(REC_CYC - 1);
                state_d  = ST_WREC;
            end
            ST_WREC: if (tmr_expired) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            strb_q    <= strobes_for(ST_IDLE);
            addr_q    <= '0;
            wdata_q   <= '0;
            mask_q    <= '0;
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            state_q   <= state_d;
            strb_q    <= strobes_for(state_d);
            rsp_valid <= capture;
            if (accept) begin
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
                mask_q  <= req_mask;
            end
            if (capture) rsp_rdata <= rd_masked;
        end
    end

    sram_ctl_lanes #(.DATA_W(DATA_W)) lanes_i (
        .active    (~strb_q.cs1_n),
        .mask      (mask_q),
        .dq_in     (ram_dq_i),
        .be_n      (ram_be_n),
        .rd_masked (rd_masked)
    );

    assign ram_addr  = addr_q;
    assign ram_cs1_n = strb_q.cs1_n;
    assign ram_cs2   = strb_q.cs2;
    assign ram_we_n  = strb_q.we_n;
    assign ram_oe_n  = strb_q.oe_n;
    assign ram_dq_oe = strb_q.dq_oe;
    assign ram_dq_o  = wdata_q;

    AST_SEL_PAIR: assert property (@(posedge clk) disable iff (rst)
        ram_cs1_n == !ram_cs2); // R2
    AST_STANDBY_LANES: assert property (@(posedge clk) disable iff (rst)
        ram_cs1_n |-> (&ram_be_n)); // R2
    AST_WE_DRIVES: assert property (@(posedge clk) disable iff (rst)
        !ram_we_n |-> (ram_dq_oe && !ram_cs1_n)); // R3
    AST_NO_FIGHT: assert property (@(posedge clk) disable iff (rst)
        !(ram_dq_oe && !ram_oe_n)); // R6
    AST_OE_WE_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(!ram_oe_n && !ram_we_n)); // R6
    AST_BUSY: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready); // R7
    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!ram_cs1_n && !$past(ram_cs1_n)) |-> $stable(ram_addr)); // R8
    AST_RSP_PULSE: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid); // R5

endmodule

// File: tb/sram_bus_ctl_tb_top.sv
module sram_bus_ctl_tb_top;
    localparam int AW = 19, DW = 16, NL = 2;
    localparam int RC_EXP = 11, WP_EXP = 9, WC_EXP = 11;

    logic clk = 1'b0, rst = 1'b1;
    logic req_valid = 1'b0, req_we = 1'b0, req_ready, rsp_valid;
    logic [AW-1:0] req_addr = '0, ram_addr;
    logic [DW-1:0] req_wdata = '0, rsp_rdata, ram_dq_o, ram_dq_i;
    logic [NL-1:0] req_mask = '0, ram_be_n;
    logic ram_cs1_n, ram_cs2, ram_we_n, ram_oe_n, ram_dq_oe;

    int checks = 0, fails = 0;
    logic [DW-1:0] ram_mem [64];
    logic [DW-1:0] exp_mem [64];
    logic [AW-1:0] cur_addr;
    logic          in_flight = 1'b0;

    always #4 clk = ~clk;

    sram_bus_ctl dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_mask(req_mask), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .ram_addr(ram_addr), .ram_cs1_n(ram_cs1_n), .ram_cs2(ram_cs2),
        .ram_be_n(ram_be_n), .ram_we_n(ram_we_n), .ram_oe_n(ram_oe_n),
        .ram_dq_o(ram_dq_o), .ram_dq_oe(ram_dq_oe), .ram_dq_i(ram_dq_i)
    );

    // RAM model: drives only enabled lanes on a read, garbage elsewhere
    logic sel;
    assign sel = !ram_cs1_n && ram_cs2;
    always_comb begin
        for (int l = 0; l < NL; l++)
            ram_dq_i[l*8 +: 8] = (sel && !ram_oe_n && ram_we_n && !ram_be_n[l])
                                 ? ram_mem[ram_addr[5:0]][l*8 +: 8] : 8'hA5;
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] merge(logic [DW-1:0] old, logic [DW-1:0] nw,
                                            logic [NL-1:0] m);
        logic [DW-1:0] r = old;
        for (int l = 0; l < NL; l++) if (m[l]) r[l*8 +: 8] = nw[l*8 +: 8];
        return r;
    endfunction

    function automatic logic [DW-1:0] mask_rd(logic [DW-1:0] d, logic [NL-1:0] m);
        return merge('0, d, m);
    endfunction

    // Pin monitor, sampled at the falling edge
    int we_run = 0, oe_run = 0, sel_run = 0;
    logic prev_we_n = 1'b1, prev_oe_n = 1'b1, prev_sel = 1'b0, prev_wr = 1'b0;
    always @(negedge clk) if (!rst) begin
        if (ram_dq_oe && !ram_oe_n) check(0, "R6 contention", 1, 0);
        if (!sel && !(&ram_be_n)) check(0, "R2 lanes in standby", ram_be_n, 2'b11);
        if (sel && in_flight && ram_addr != cur_addr) check(0, "R8 addr", ram_addr, cur_addr);
        if (prev_we_n && !ram_we_n && prev_sel) check(0, "R3 we after selects", 0, 1);
        if (!prev_we_n && ram_we_n) begin
            check(we_run == WP_EXP, "R3 we width", we_run, WP_EXP);
            if (sel)
                for (int l = 0; l < NL; l++)
                    if (!ram_be_n[l]) ram_mem[ram_addr[5:0]][l*8 +: 8] = ram_dq_o[l*8 +: 8];
        end
        if (!prev_oe_n && ram_oe_n) check(oe_run == RC_EXP, "R5 oe width", oe_run, RC_EXP);
        if (prev_sel && !sel && prev_wr)
            check(sel_run == WC_EXP, "R3 write select span", sel_run, WC_EXP);
        if (sel && !ram_we_n) prev_wr = 1'b1; else if (!sel) prev_wr = 1'b0;
        we_run  = ram_we_n ? 0 : we_run + 1;
        oe_run  = ram_oe_n ? 0 : oe_run + 1;
        sel_run = sel ? sel_run + 1 : 0;
        prev_we_n = ram_we_n; prev_oe_n = ram_oe_n; prev_sel = sel;
    end

    task automatic access(input bit we, input logic [AW-1:0] a, input logic [DW-1:0] d,
                          input logic [NL-1:0] m);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_we = we; req_addr = a; req_wdata = d; req_mask = m;
        @(negedge clk);
        req_valid = 1'b0;
        cur_addr = a; in_flight = 1'b1;
        check(!req_ready, "R7 busy after accept", req_ready, 0);
        while (!req_ready) @(negedge clk);
        in_flight = 1'b0;
        if (we) begin
            exp_mem[a[5:0]] = merge(exp_mem[a[5:0]], d, m);
        end else begin
            logic [DW-1:0] e = mask_rd(exp_mem[a[5:0]], m);
            check(rsp_valid, "R5 rsp pulse", rsp_valid, 1);
            check(rsp_rdata == e, (m == 0) ? "R9 empty mask read" : "R4 R5 read data",
                  rsp_rdata, e);
            @(negedge clk);
            check(!rsp_valid, "R5 pulse one cycle", rsp_valid, 0);
        end
    endtask

    task automatic finish_run;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    endtask

    initial begin
        #(8 * 200000);
        check(0, "watchdog", 0, 1);
        finish_run();
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        for (int i = 0; i < 64; i++) begin ram_mem[i] = '0; exp_mem[i] = '0; end
        repeat (3) @(negedge clk);
        check(ram_cs1_n && !ram_cs2 && (&ram_be_n) && ram_we_n && ram_oe_n && !ram_dq_oe
              && req_ready, "R1 reset state", {ram_cs1_n, ram_cs2, ram_be_n, ram_we_n,
              ram_oe_n, ram_dq_oe, req_ready}, 8'b1011_1101);
        rst = 1'b0;
        @(negedge clk);
        check(ram_cs1_n && !ram_cs2 && req_ready, "R1 after reset", ram_cs1_n, 1);
        // Directed corners
        access(1, 19'h7FFC1, 16'hBEEF, 2'b11);
        access(0, 19'h7FFC1, 16'h0000, 2'b11);
        access(1, 19'h00001, 16'h1234, 2'b01);   // R4 lower lane only
        access(0, 19'h00001, 16'h0000, 2'b11);
        access(1, 19'h00001, 16'hAB00, 2'b10);   // R4 upper lane only
        access(0, 19'h00001, 16'h0000, 2'b10);
        access(1, 19'h00001, 16'hFFFF, 2'b00);   // R9 no change
        access(0, 19'h00001, 16'h0000, 2'b11);
        access(0, 19'h00001, 16'h0000, 2'b00);   // R9 read zero
        // Random mix over a small window, high address bits varied
        for (int n = 0; n < 300; n++) begin
            logic [AW-1:0] a;
            a = {13'($urandom), 6'($urandom_range(0, 7))};
            access(1'($urandom), a, 16'($urandom), 2'($urandom));
        end
        for (int i = 0; i < 8; i++) access(0, 19'(i), 16'h0, 2'b11);
        finish_run();
    end

endmodule